// File: doc/BRIEF.md
# Parallel Port FIFO Service Interrupt Controller

This block holds the extended control state for the byte FIFO of an 8-bit extended-capability parallel port. It decides when that FIFO needs attention from software or from the DMA engine, and it turns that decision into a single interrupt line. Software reaches it through three byte registers at offsets 0, 1 and 2. Offset 2 is the extended control register. It holds a 3-bit mode, a fault-interrupt disable, a DMA enable and a service-interrupt mask. It also reports FIFO full and empty as read-only status. Offsets 0 and 1 are identification registers, and they open only in configuration mode (3'b111).

The service interrupt disables itself. Once it fires, hardware sets the mask bit, and software must clear that bit to arm the interrupt again. The condition it watches depends on the DMA enable and on the transfer direction. It is the DMA terminal count, enough free space for a forward transfer, or enough valid data for a reverse transfer. A falling edge on the active-low fault pin raises the same interrupt line while the port is in ECP mode (3'b011). A fault that is already present is not lost when software re-enables fault interrupts.

All register writes take effect at the clock edge. The interrupt output is a registered one-cycle pulse in the cycle after its cause.

Top module: `ecpSvcIntr`

## Requirements
- R1: After reset the control register at offset 2 holds mode 000, fault disable 0, DMA enable 0 and service mask 1. With an empty FIFO it therefore reads 0x05. The interrupt output and the DMA go output are both 0.
- R2: Register offset 2 has this layout: bits 7:5 mode, bit 4 fault disable, bit 3 DMA enable, bit 2 service mask. These bits read back what was last written, except where R4 to R6 set bit 2. Bit 1 reads 1 when the FIFO count is 16 or more. Bit 0 reads 1 when the count is 0. Writes to bits 1:0 are ignored.
- R3: The DMA go output is 1 exactly when the DMA enable is 1 and the service mask is 0.
- R4: With DMA enable 1 and service mask 0, a terminal-count pulse sets the service mask. It also raises the interrupt output for one cycle, in the cycle after the pulse. The mask then stays 1 until software writes 0 to it.
- R5: With DMA enable 0, direction 0 and service mask 0, the service interrupt fires when free space (16 minus count) is at least 8, that is when the count is 8 or less. A count of 9 does not fire it.
- R6: With DMA enable 0, direction 1 and service mask 0, the service interrupt fires when the count is at least 8. A count of 7 does not fire it.
- R7: No service interrupt fires while the service mask is 1. A write of 1 to the mask never causes an interrupt, even in a cycle where a service condition holds and the mask was 0.
- R8: In mode 011 with fault disable 0, a high-to-low transition on nFault raises the interrupt for one cycle. With fault disable 1, or in any other mode, it does not.
- R9: In mode 011, a write that changes the fault disable bit from 1 to 0 while nFault is low raises the interrupt for one cycle.
- R10: In mode 111, offset 0 reads 0x10. Offset 1 reads bit 7 as 0, bit 6 as the current interrupt output, and bits 5:0 as 0. In other modes both offsets read 0x00. Offset 3 always reads 0x00. Writes to offsets 0, 1 and 3 change nothing.
- R11: The interrupt output is a registered pulse one cycle wide for each firing cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 2 | Register offset |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Combinational read data for regAddr |
| fifoCount | input | 5 | Bytes currently held in the FIFO (0 to 16) |
| dirIn | input | 1 | Transfer direction: 0 forward, 1 reverse |
| dmaTc | input | 1 | DMA terminal-count pulse |
| nFault | input | 1 | Active-low fault pin, already synchronous to clk |
| intrOut | output | 1 | Interrupt pulse |
| dmaGo | output | 1 | DMA may run |

## Verification
The assertions assume three things about the inputs: nFault is already synchronous to clk, fifoCount never exceeds 16, and a register write lasts one cycle with stable address and data. The fault-edge and cause properties compare nFault across adjacent cycles, so they rely on that pin being a clean synchronous level. The random stimulus keeps the count within 0 to 16, flips nFault only at clock-aligned points, and drives every write for one cycle. It spends most writes on offset 2 and makes occasional stray writes to the other offsets.

// File: rtl/ecpSvcPkg.sv
package ecpSvcPkg;

  localparam logic [1:0] ADDR_CFGA = 2'd0;
  localparam logic [1:0] ADDR_CFGB = 2'd1;
  localparam logic [1:0] ADDR_ECR  = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic ecrWr;
    logic svcFire;
    logic faultFire;
  } ctrlStrobes_t;

  // stored part of the extended control register
  typedef struct packed {
    logic [2:0] mode;
    logic       errDis;
    logic       dmaEn;
    logic       svc;
  } ecrState_t;

endpackage

// File: rtl/ecpSvcCtrl.sv
module ecpSvcCtrl
  import ecpSvcPkg::*;
#(
  parameter int         DEPTH    = 16,
  parameter int         CNT_W    = $clog2(DEPTH + 1),
  parameter int         WR_THR   = 8,
  parameter int         RD_THR   = 8,
  parameter logic [2:0] ECP_MODE = 3'b011
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic [1:0]       regAddr,
  input  logic [7:0]       regWrData,
  input  logic [CNT_W-1:0] fifoCount,
  input  logic             dirIn,
  input  logic             dmaTc,
  input  logic             nFault,
  input  ecrState_t        ecrQ,
  output ctrlStrobes_t     strobes
);

  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] WR_THR_C = CNT_W'(WR_THR);
  localparam logic [CNT_W-1:0] RD_THR_C = CNT_W'(RD_THR);

  logic             prevNFault;
  logic             wrHit;
  logic [CNT_W-1:0] freeCnt;
  logic             svcCond;
  logic             inEcp;
  logic             faultEdge;
  logic             rearm;

  always_ff @(posedge clk) begin
    if (!rstN) prevNFault <= 1'b1;
    else       prevNFault <= nFault;
  end

  assign wrHit   = regWr && (regAddr == ADDR_ECR);
  assign freeCnt = DEPTH_C - fifoCount;

  always_comb begin
    if (ecrQ.dmaEn)  svcCond = dmaTc;
    else if (dirIn)  svcCond = (fifoCount >= RD_THR_C);
    else             svcCond = (freeCnt >= WR_THR_C);
  end

  assign inEcp     = (ecrQ.mode == ECP_MODE);
  assign faultEdge = prevNFault && !nFault;
  assign rearm     = wrHit && ecrQ.errDis && !regWrData[4] && !nFault;

  always_comb begin
    strobes.ecrWr     = wrHit;
    strobes.svcFire   = !ecrQ.svc && svcCond && !(wrHit && regWrData[2]);
    strobes.faultFire = inEcp && ((!ecrQ.errDis && faultEdge) || rearm);
  end

endmodule

// File: rtl/ecpSvcRegs.sv
module ecpSvcRegs
  import ecpSvcPkg::*;
#(
  parameter int         DEPTH     = 16,
  parameter int         CNT_W     = $clog2(DEPTH + 1),
  parameter logic [2:0] CFG_MODE  = 3'b111,
  parameter logic [7:0] CFG_A_VAL = 8'h10
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [1:0]       regAddr,
  input  logic [7:0]       regWrData,
  input  logic [CNT_W-1:0] fifoCount,
  output ecrState_t        ecrQ,
  output logic             intrOut,
  output logic             dmaGo,
  output logic [7:0]       regRdData
);

  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  ecrState_t ecrNext;
  logic      fullS;
  logic      emptyS;
  logic      cfgOpen;

  always_comb begin
    ecrNext = ecrQ;
    if (strobes.ecrWr) begin
      ecrNext.mode   = regWrData[7:5];
      ecrNext.errDis = regWrData[4];
      ecrNext.dmaEn  = regWrData[3];
      ecrNext.svc    = regWrData[2];
    end
    if (strobes.svcFire) ecrNext.svc = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ecrQ    <= '{mode: 3'b000, errDis: 1'b0, dmaEn: 1'b0, svc: 1'b1};
      intrOut <= 1'b0;
    end else begin
      ecrQ    <= ecrNext;
      intrOut <= strobes.svcFire || strobes.faultFire;
    end
  end

  assign fullS   = (fifoCount >= DEPTH_C);
  assign emptyS  = (fifoCount == '0);
  assign cfgOpen = (ecrQ.mode == CFG_MODE);
  assign dmaGo   = ecrQ.dmaEn && !ecrQ.svc;

  always_comb begin
    unique case (regAddr)
      ADDR_CFGA: regRdData = cfgOpen ? CFG_A_VAL : 8'h00;
      ADDR_CFGB: regRdData = cfgOpen ? {1'b0, intrOut, 6'b0} : 8'h00;
      ADDR_ECR:  regRdData = {ecrQ.mode, ecrQ.errDis, ecrQ.dmaEn, ecrQ.svc, fullS, emptyS};
      default:   regRdData = 8'h00;
    endcase
  end

endmodule

// File: rtl/ecpSvcIntr.sv
module ecpSvcIntr
  import ecpSvcPkg::*;
#(
  parameter int         DEPTH    = 16,
  parameter int         CNT_W    = $clog2(DEPTH + 1),
  parameter int         WR_THR   = 8,
  parameter int         RD_THR   = 8,
  parameter logic [2:0] ECP_MODE = 3'b011,
  parameter logic [2:0] CFG_MODE = 3'b111
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic [1:0]       regAddr,
  input  logic [7:0]       regWrData,
  output logic [7:0]       regRdData,
  input  logic [CNT_W-1:0] fifoCount,
  input  logic             dirIn,
  input  logic             dmaTc,
  input  logic             nFault,
  output logic             intrOut,
  output logic             dmaGo
);

  ctrlStrobes_t strobes;
  ecrState_t    ecrQ;
  logic         svcBit;
  logic         dmaEnBit;
  logic         errDisBit;
  logic [2:0]   modeBits;

  ecpSvcCtrl #(
    .DEPTH(DEPTH), .CNT_W(CNT_W), .WR_THR(WR_THR), .RD_THR(RD_THR), .ECP_MODE(ECP_MODE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWrData(regWrData),
    .fifoCount(fifoCount), .dirIn(dirIn), .dmaTc(dmaTc), .nFault(nFault),
    .ecrQ(ecrQ), .strobes(strobes)
  );

  ecpSvcRegs #(
    .DEPTH(DEPTH), .CNT_W(CNT_W), .CFG_MODE(CFG_MODE), .CFG_A_VAL(8'h10)
  ) u_regs (
    .clk(clk), .rstN(rstN), .strobes(strobes), .regAddr(regAddr), .regWrData(regWrData),
    .fifoCount(fifoCount), .ecrQ(ecrQ), .intrOut(intrOut), .dmaGo(dmaGo),
    .regRdData(regRdData)
  );

  assign svcBit    = ecrQ.svc;
  assign dmaEnBit  = ecrQ.dmaEn;
  assign errDisBit = ecrQ.errDis;
  assign modeBits  = ecrQ.mode;

endmodule

// File: rtl/ecpSvcIntrChk.sv
module ecpSvcIntrChk #(
  parameter logic [2:0] ECP_MODE = 3'b011
) (
  input logic       clk,
  input logic       rstN,
  input logic       regWr,
  input logic [1:0] regAddr,
  input logic [7:0] regWrData,
  input logic       nFault,
  input logic       dmaTc,
  input logic       intrOut,
  input logic       svcBit,
  input logic       dmaEnBit,
  input logic       errDisBit,
  input logic [2:0] modeBits
);

  logic ecrWr;
  assign ecrWr = regWr && (regAddr == 2'd2);

  // R4
  svc_tc_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!svcBit && dmaEnBit && dmaTc && !(ecrWr && regWrData[2])) |=> (svcBit && intrOut));

  // R4
  svc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (svcBit && !(ecrWr && !regWrData[2])) |=> svcBit);

  // R8
  fault_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeBits == ECP_MODE && !errDisBit && $fell(nFault)) |=> intrOut);

  // R11
  intr_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    intrOut |-> ($past(!svcBit) || $past(!nFault)));

  // R7
  write1_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ecrWr && regWrData[2] && modeBits != ECP_MODE) |=> !intrOut);

endmodule

bind ecpSvcIntr ecpSvcIntrChk #(.ECP_MODE(ECP_MODE)) u_chk (
  .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWrData(regWrData),
  .nFault(nFault), .dmaTc(dmaTc), .intrOut(intrOut), .svcBit(svcBit),
  .dmaEnBit(dmaEnBit), .errDisBit(errDisBit), .modeBits(modeBits)
);

// File: tb/ecpSvcIntr_bench.sv
module ecpSvcIntr_bench;
  localparam int DEPTH = 16;
  localparam int CW    = 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWr = 1'b0;
  logic [1:0]    regAddr = 2'd2;
  logic [7:0]    regWrData = 8'h00;
  logic [7:0]    regRdData;
  logic [CW-1:0] fifoCount = '0;
  logic          dirIn = 1'b0;
  logic          dmaTc = 1'b0;
  logic          nFault = 1'b1;
  logic          intrOut;
  logic          dmaGo;

  int total = 0;
  int bad   = 0;

  // requirement model
  logic [2:0] mMode = 3'b000;
  logic       mErrDis = 1'b0, mDmaEn = 1'b0, mSvc = 1'b1, mPrevNf = 1'b1, mIntr = 1'b0;

  always #4 clk = ~clk;

  ecpSvcIntr u_ecpSvcIntr (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .fifoCount(fifoCount), .dirIn(dirIn), .dmaTc(dmaTc),
    .nFault(nFault), .intrOut(intrOut), .dmaGo(dmaGo)
  );

  function automatic logic [7:0] ecrExp();
    logic fullE, emptyE;
    fullE  = (int'(fifoCount) >= DEPTH);
    emptyE = (fifoCount == '0);
    return {mMode, mErrDis, mDmaEn, mSvc, fullE, emptyE};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic modelStep();
    logic wrE, cond, svcF, fltF;
    int   freeB;
    wrE   = regWr && (regAddr == 2'd2);
    freeB = DEPTH - int'(fifoCount);
    if (mDmaEn)     cond = dmaTc;
    else if (dirIn) cond = (int'(fifoCount) >= 8);
    else            cond = (freeB >= 8);
    svcF = !mSvc && cond && !(wrE && regWrData[2]);
    fltF = (mMode == 3'b011) &&
           ((!mErrDis && mPrevNf && !nFault) || (wrE && mErrDis && !regWrData[4] && !nFault));
    if (wrE) begin
      mMode   = regWrData[7:5];
      mErrDis = regWrData[4];
      mDmaEn  = regWrData[3];
      mSvc    = regWrData[2];
    end
    if (svcF) mSvc = 1'b1;
    mPrevNf = nFault;
    mIntr   = svcF || fltF;
  endtask

  task automatic tick();
    modelStep();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wrEcr(input logic [7:0] d);
    regWr = 1'b1; regAddr = 2'd2; regWrData = d;
    tick();
    regWr = 1'b0;
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL R11 watchdog act=running exp=finished");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chk("R1 ecr", regRdData, 8'h05);
    chk("R1 intr", {7'b0, intrOut}, 8'h00);
    chk("R1 dmaGo", {7'b0, dmaGo}, 8'h00);

    // R10 config registers
    regAddr = 2'd0; #1;
    chk("R10 cfgA closed", regRdData, 8'h00);
    wrEcr(8'hE4);
    regAddr = 2'd0; #1;
    chk("R10 cfgA open", regRdData, 8'h10);
    regAddr = 2'd1; #1;
    chk("R10 cfgB open", regRdData, 8'h00);
    regAddr = 2'd3; #1;
    chk("R10 offset3", regRdData, 8'h00);
    regWr = 1'b1; regAddr = 2'd0; regWrData = 8'h00; tick();
    regAddr = 2'd1; tick();
    regAddr = 2'd3; tick();
    regWr = 1'b0; regAddr = 2'd2; #1;
    chk("R10 stray writes", regRdData, 8'hE5);

    // R2 bits 1:0 ignore writes, reflect status
    fifoCount = 5'd16;
    wrEcr(8'hE7);
    chk("R2 full status", regRdData, 8'hE6);

    // R5 forward threshold
    dirIn = 1'b0; fifoCount = 5'd9;
    wrEcr(8'hE0);
    tick();
    chk("R5 count9 no intr", {7'b0, intrOut}, 8'h00);
    chk("R5 count9 mask", regRdData, 8'hE0);
    fifoCount = 5'd8;
    tick();
    chk("R5 count8 intr", {7'b0, intrOut}, 8'h01);
    chk("R5 mask set", regRdData, 8'hE4);
    regAddr = 2'd1; #1;
    chk("R10 cfgB intr level", regRdData, 8'h40);
    regAddr = 2'd2;
    tick();
    chk("R11 pulse width", {7'b0, intrOut}, 8'h00);

    // R6 reverse threshold
    dirIn = 1'b1; fifoCount = 5'd7;
    wrEcr(8'hE0);
    tick();
    chk("R6 count7 no intr", {7'b0, intrOut}, 8'h00);
    fifoCount = 5'd8;
    tick();
    chk("R6 count8 intr", {7'b0, intrOut}, 8'h01);

    // R4 / R3 DMA terminal count
    dirIn = 1'b0; fifoCount = 5'd4;
    wrEcr(8'hE8);
    chk("R3 dmaGo on", {7'b0, dmaGo}, 8'h01);
    tick();
    chk("R4 no tc no intr", {7'b0, intrOut}, 8'h00);
    dmaTc = 1'b1; tick(); dmaTc = 1'b0;
    chk("R4 tc intr", {7'b0, intrOut}, 8'h01);
    chk("R3 dmaGo off", {7'b0, dmaGo}, 8'h00);
    chk("R4 mask set", regRdData, 8'hEC);
    tick();
    chk("R4 mask stays", regRdData, 8'hEC);

    // R7 writing 1 never fires
    dirIn = 1'b1; fifoCount = 5'd16;
    wrEcr(8'hE0);
    wrEcr(8'hE4);
    chk("R7 write1 no intr", {7'b0, intrOut}, 8'h00);
    tick();
    chk("R7 masked no intr", {7'b0, intrOut}, 8'h00);

    // R8 / R9 fault pin
    fifoCount = 5'd4; dirIn = 1'b0;
    wrEcr(8'h64);
    nFault = 1'b0; tick();
    chk("R8 fault edge", {7'b0, intrOut}, 8'h01);
    nFault = 1'b1; tick();
    wrEcr(8'h74);
    nFault = 1'b0; tick();
    chk("R8 fault disabled", {7'b0, intrOut}, 8'h00);
    wrEcr(8'h64);
    chk("R9 rearm", {7'b0, intrOut}, 8'h01);
    wrEcr(8'hE4);
    nFault = 1'b1; tick();
    nFault = 1'b0; tick();
    chk("R8 other mode", {7'b0, intrOut}, 8'h00);

    // constrained random against the model
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] mSel;
      fifoCount = CW'($urandom_range(0, DEPTH));
      dirIn     = $urandom_range(0, 1) == 1;
      dmaTc     = ($urandom_range(0, 5) == 0);
      if ($urandom_range(0, 7) == 0) nFault = ~nFault;
      regWr = ($urandom_range(0, 4) == 0);
      if (regWr && $urandom_range(0, 5) == 0) regAddr = 2'($urandom_range(0, 3));
      else regAddr = 2'd2;
      case ($urandom_range(0, 3))
        0: mSel = 3'b011;
        1: mSel = 3'b111;
        2: mSel = 3'b000;
        default: mSel = 3'($urandom_range(0, 7));
      endcase
      regWrData = {mSel, 5'($urandom_range(0, 31))};
      tick();
      regWr = 1'b0;
      chk("R11 random intr", {7'b0, intrOut}, {7'b0, mIntr});
      chk("R3 random dmaGo", {7'b0, dmaGo}, {7'b0, mDmaEn && !mSvc});
      if (regAddr == 2'd2) chk("R2 random ecr", regRdData, ecrExp());
    end

    finishRun();
  end
endmodule